// File: doc/BRIEF.md
# Level-Qualified Overflow Timer

This block is an 8-bit up-counter with one mode register that a CPU reads and writes over a simple bus. The counter takes one step on each cycle in which the selected bit of a four-bit prescaler enable vector is high. The mode register picks which of the four enables drives the counter.

When the counter wraps from 0xFF to 0x00, one of two sticky overflow flags is set. The flag is chosen by the synchronized level of an external capture input. In interval operation, every wrap goes to the low-level flag.

Software clears a flag with two steps. It must first read the flag as 1, then write 0 to it. An interrupt output is raised while the enable bit is set and either flag is set. The counter can also be cleared on capture-input edges, as chosen by a two-bit select field.

Top module: `ovf_timer`

## Requirements
- R1: After reset the mode register reads 0x00, the counter reads 0x00 and irq is low.
- R2: Address 0 is the mode register and address 1 returns the counter (read-only). The mode register bits are:
  - bit 7: high-level flag
  - bit 6: low-level flag
  - bit 5: interrupt enable
  - bit 4: edge select (stored and read back only)
  - bits 3:2: clear select
  - bits 1:0: clock select

  Bits 5:0 read back as written.
- R3: A wrap from 0xFF to 0x00 sets bit 7 when the synchronized capture level is 1 and intervalMode is 0.
- R4: A wrap sets bit 6 when the synchronized capture level is 0, or whenever intervalMode is 1.
- R5: The counter advances by one on each cycle where prescEn[clock select] is 1. The other prescEn bits have no effect.
- R6: A flag clears only when a write of 0 follows a read that returned it as 1. The following have no effect on a flag:
  - a write of 0 without such a read
  - a write of 1
  - any attempt by software to set it
- R7: irq equals interrupt enable AND (bit 7 OR bit 6).
- R8: The clear select encoding is:
  - 00: no clear
  - 01: clear on a rising capture edge
  - 10: clear on a falling capture edge
  - 11: clear on both edges

  capPin passes through two flops before edge detection. The clear takes priority over an increment in the same cycle, and a cleared cycle produces no wrap.
- R9: If a hardware set and a software clear hit the same flag in one cycle, the flag stays set. Any write to the mode register disarms both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access select |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busAddr | input | 1 | 0: mode register, 1: counter |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| prescEn | input | 4 | Prescaler clock enables |
| capPin | input | 1 | Capture input |
| intervalMode | input | 1 | Selects interval operation |
| irq | output | 1 | Overflow interrupt |

## Verification
Two events can land on the same flag in the same cycle: a hardware wrap that sets it and an armed software write of 0 that clears it. The bench arms the high-level flag by reading it, counts up to 0xFF, and then asserts the last tick together with the clearing write. The flag must read 1 afterward. A second write of 0, issued with no new read, must leave the flag set, which shows that the arm bit was dropped.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;
  localparam int CNT_W = 8;
  localparam int BUS_W = 8;
  localparam int NSRC  = 4;
  localparam int SEL_W = $clog2(NSRC);

  // mode register bit positions
  localparam int B_FH   = 7;
  localparam int B_FL   = 6;
  localparam int B_IE   = 5;
  localparam int B_EDG  = 4;
  localparam int B_CLR  = 2;
  localparam int B_CKS  = 0;

  typedef struct packed {
    logic inc;
    logic clr;
  } cntStb_t;
endpackage

// File: rtl/ovf_count.sv
module ovf_count
  import ovf_timer_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  cntStb_t      stb,
  output logic [W-1:0] count,
  output logic         wrap
);
  localparam logic [W-1:0] MAXV = '1;

  assign wrap = stb.inc && !stb.clr && (count == MAXV);

  always_ff @(posedge clk) begin
    if (!rstN)        count <= '0;
    else if (stb.clr) count <= '0;
    else if (stb.inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/ovf_ctrl.sv
module ovf_ctrl
  import ovf_timer_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busRd,
  input  logic             busWr,
  input  logic             busAddr,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  input  logic [NSRC-1:0]  prescEn,
  input  logic             capPin,
  input  logic             intervalMode,
  input  logic [W-1:0]     count,
  input  logic             wrap,
  output cntStb_t          stb,
  output logic             irq
);
  logic             flagH, flagL, armH, armL;
  logic             ovie, edgeSel;
  logic [1:0]       cclr;
  logic [SEL_W-1:0] cks;
  logic [2:0]       syn;
  logic             capLvl, rise, fall, clrHit;
  logic             modeWr, modeRd, setH, setL, clrH, clrL;

  // two-flop synchronizer plus one history flop for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) syn <= '0;
    else       syn <= {syn[1:0], capPin};
  end
  assign capLvl = syn[1];
  assign rise   = syn[1] && !syn[2];
  assign fall   = !syn[1] && syn[2];

  always_comb begin
    case (cclr)
      2'b01:   clrHit = rise;
      2'b10:   clrHit = fall;
      2'b11:   clrHit = rise || fall;
      default: clrHit = 1'b0;
    endcase
  end

  assign stb.inc = prescEn[cks];
  assign stb.clr = clrHit;

  assign modeWr = busSel && busWr && !busAddr;
  assign modeRd = busSel && busRd && !busWr && !busAddr;
  assign setH   = wrap && capLvl && !intervalMode;
  assign setL   = wrap && (!capLvl || intervalMode);
  assign clrH   = modeWr && !busWdata[B_FH] && armH;
  assign clrL   = modeWr && !busWdata[B_FL] && armL;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagH <= 1'b0; flagL <= 1'b0; armH <= 1'b0; armL <= 1'b0;
      ovie <= 1'b0; edgeSel <= 1'b0; cclr <= '0; cks <= '0;
    end else begin
      flagH <= setH || (flagH && !clrH);
      flagL <= setL || (flagL && !clrL);
      if (modeWr) begin
        armH    <= 1'b0;
        armL    <= 1'b0;
        ovie    <= busWdata[B_IE];
        edgeSel <= busWdata[B_EDG];
        cclr    <= busWdata[B_CLR +: 2];
        cks     <= busWdata[B_CKS +: SEL_W];
      end else if (modeRd) begin
        if (flagH) armH <= 1'b1;
        if (flagL) armL <= 1'b1;
      end
    end
  end

  assign busRdata = busAddr ? BUS_W'(count)
                            : {flagH, flagL, ovie, edgeSel, cclr, cks};
  assign irq = ovie && (flagH || flagL);
endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
  import ovf_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busRd,
  input  logic             busWr,
  input  logic             busAddr,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  input  logic [NSRC-1:0]  prescEn,
  input  logic             capPin,
  input  logic             intervalMode,
  output logic             irq
);
  cntStb_t          stb;
  logic [CNT_W-1:0] count;
  logic             wrap;

  ovf_ctrl #(.W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .prescEn(prescEn), .capPin(capPin), .intervalMode(intervalMode),
    .count(count), .wrap(wrap), .stb(stb), .irq(irq)
  );

  ovf_count #(.W(CNT_W)) u_cnt (
    .clk(clk), .rstN(rstN), .stb(stb), .count(count), .wrap(wrap)
  );
endmodule

// File: rtl/ovf_timer_chk.sv
module ovf_timer_chk (
  input logic clk,
  input logic rstN,
  input logic busSel,
  input logic busWr,
  input logic busAddr,
  input logic intervalMode,
  input logic irq,
  input logic wrap,
  input logic capLvl,
  input logic flagH,
  input logic flagL,
  input logic ovie
);
  logic wrMode;
  assign wrMode = busSel && busWr && !busAddr;

  a_r3_high_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrap && capLvl && !intervalMode) |=> flagH);
  a_r4_low_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrap && (!capLvl || intervalMode)) |=> flagL);
  a_r6_no_sw_set_h: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagH) |-> $past(wrap));
  a_r6_no_sw_set_l: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagL) |-> $past(wrap));
  a_r6_hold_h: assert property (@(posedge clk) disable iff (!rstN)
    (flagH && !wrMode) |=> flagH);
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    !ovie |-> !irq);
  a_r7_irq_on: assert property (@(posedge clk) disable iff (!rstN)
    (ovie && (flagH || flagL)) |-> irq);
endmodule

bind ovf_timer ovf_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .intervalMode(intervalMode), .irq(irq), .wrap(wrap),
  .capLvl(u_ctrl.capLvl), .flagH(u_ctrl.flagH), .flagL(u_ctrl.flagL),
  .ovie(u_ctrl.ovie)
);

// File: tb/sim_ovf_timer.sv
module sim_ovf_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busRd = 1'b0, busWr = 1'b0, busAddr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [3:0] prescEn = '0;
  logic       capPin = 1'b0, intervalMode = 1'b0;
  logic       irq;
  int         checks = 0, errors = 0;
  logic [7:0] rv;

  ovf_timer u0 (.*);

  always #5 clk = ~clk;

  // {cks[1:0], cap, interval, expH, expL}
  localparam logic [5:0] VEC [4] = '{
    6'b00_1_0_1_0, 6'b01_0_0_0_1, 6'b10_1_1_0_1, 6'b11_0_1_0_1 };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; prescEn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic busWrite(input logic a, input logic [7:0] d);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic busRead(input logic a, output logic [7:0] d);
    busSel = 1; busRd = 1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 0; busRd = 0;
  endtask

  task automatic tick(input int n, input logic [3:0] en);
    prescEn = en;
    repeat (n) @(negedge clk);
    prescEn = '0;
  endtask

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    doReset();
    busRead(0, rv); chk("R1 mode", rv, 8'h00);
    busRead(1, rv); chk("R1 count", rv, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R3 R4 R5: vector table, one full wrap each
    foreach (VEC[i]) begin
      doReset();
      busWrite(0, {6'b0, VEC[i][5:4]});
      capPin = VEC[i][3]; intervalMode = VEC[i][2];
      repeat (3) @(negedge clk);
      tick(256, 4'b0001 << VEC[i][5:4]);
      busRead(0, rv);
      chk("R3/R4 flags", {6'b0, rv[7:6]}, {6'b0, VEC[i][1:0]});
      busRead(1, rv); chk("R5 wrap count", rv, 8'h00);
    end
    capPin = 0; intervalMode = 0;

    // R2 bits 5:0 read back
    doReset();
    busWrite(0, 8'h3F); busRead(0, rv); chk("R2 readback", rv, 8'h3F);
    busWrite(0, 8'h15); busRead(0, rv); chk("R2 readback", rv, 8'h15);

    // R5 unselected enables ignored
    doReset();
    busWrite(0, 8'h02);
    tick(10, 4'b1011); busRead(1, rv); chk("R5 unselected", rv, 8'h00);
    tick(7, 4'b0100);  busRead(1, rv); chk("R5 selected", rv, 8'h07);

    // R6 read-then-write-zero clearing
    doReset();
    capPin = 1; repeat (3) @(negedge clk);
    tick(256, 4'b0001);
    busWrite(0, 8'h00); busRead(0, rv); chk("R6 no read no clear", rv, 8'h80);
    busWrite(0, 8'h00); busRead(0, rv); chk("R6 armed clear", rv, 8'h00);
    busWrite(0, 8'hC0); busRead(0, rv); chk("R6 sw cannot set", rv, 8'h00);

    // R7 interrupt gating
    doReset();
    capPin = 0; busWrite(0, 8'h20); repeat (3) @(negedge clk);
    tick(256, 4'b0001);
    chk("R7 irq on", {7'b0, irq}, 8'h01);
    busWrite(0, 8'h00); chk("R7 irq off", {7'b0, irq}, 8'h00);
    busWrite(0, 8'h20); chk("R7 irq again", {7'b0, irq}, 8'h01);

    // R8 capture-edge clear select
    doReset();
    capPin = 0; busWrite(0, 8'h04); repeat (3) @(negedge clk);
    tick(5, 4'b0001);
    capPin = 1; repeat (4) @(negedge clk);
    busRead(1, rv); chk("R8 rising clears", rv, 8'h00);
    tick(5, 4'b0001);
    capPin = 0; repeat (4) @(negedge clk);
    busRead(1, rv); chk("R8 falling ignored on 01", rv, 8'h05);
    busWrite(0, 8'h08);
    capPin = 1; repeat (4) @(negedge clk);
    busRead(1, rv); chk("R8 rising ignored on 10", rv, 8'h05);
    capPin = 0; repeat (4) @(negedge clk);
    busRead(1, rv); chk("R8 falling clears", rv, 8'h00);
    busWrite(0, 8'h00); tick(3, 4'b0001);
    capPin = 1; repeat (4) @(negedge clk);
    busRead(1, rv); chk("R8 no clear on 00", rv, 8'h03);

    // R9 hardware set beats armed clear in the same cycle
    doReset();
    capPin = 1; busWrite(0, 8'h00); repeat (3) @(negedge clk);
    tick(256, 4'b0001);
    busRead(0, rv); chk("R9 flag before", rv, 8'h80);
    tick(255, 4'b0001);
    busRead(1, rv); chk("R9 count at max", rv, 8'hFF);
    prescEn = 4'b0001; busSel = 1; busWr = 1; busAddr = 0; busWdata = 8'h00;
    @(negedge clk);
    prescEn = '0; busSel = 0; busWr = 0;
    busWrite(0, 8'h00);
    busRead(0, rv); chk("R9 set wins and write disarms", rv, 8'h80);
    busRead(1, rv); chk("R9 count wrapped", rv, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule